// File: doc/BRIEF.md
# Frequency-Hopping Lookup-Table Oscillator

This block is a numerically controlled oscillator. On every clock a 24-bit phase register advances by a base step word plus a frequency offset, and wraps around modulo 2^24. The upper ten bits of the phase address a table that holds one full period of a waveform, and the table returns a signed 8-bit sample. The output frequency is the effective step times the clock rate divided by 2^24. By default the table holds a sine wave.

The frequency offset comes from one of four offset registers that are loaded through a small write port. In keyed mode a 2-bit symbol input picks the register, which gives frequency shift keying. In hopping mode a 16-bit maximal-length shift register picks the register instead. The shift register steps once after each programmable number of cycles, so the carrier jumps between the four frequencies in a pseudo-random order. This is useful for spread-spectrum links.

Top module: `hop_nco`

## Requirements
- R1: A synchronous active-high `rst` clears the phase, the offset registers, the select and both pipeline stages, so `sample` reads 0 and `sample_valid` reads 0. After `rst` is released, `sample_valid` first reads 1 after the second rising edge and stays at 1.
- R2: On each clock, phase becomes (phase + `phase_inc` + selected offset) mod 2^24. The sample present after edge k equals the table entry at phase[23:14] as it stood after edge k-2, where the phase after the reset edge is 0.
- R3: Table entry k (for k from 0 to 1023) is round(127·sin(2πk/1024)), with halves rounded away from zero, in two's complement. The value -128 never appears.
- R4: When `hop_en` is 0, the offset register indexed by `fsk_sym` is registered as the select, so a symbol change alters the phase step from the second edge after it is applied.
- R5: When `ofs_we` is 1, an edge loads `ofs_data` into the offset register indexed by `ofs_sel`. The phase step uses the new value from the following edge onward.
- R6: When `hop_en` is 1, bits [1:0] of the hop shift register drive the select in place of `fsk_sym`, and `fsk_sym` has no effect.
- R7: The hop shift register is seeded with 16'hACE1. Its new bit 0 is b15^b13^b12^b10, and the register shifts left. While `hop_en` is 1, it steps on every `dwell_len`-th edge, and a `dwell_len` of 0 behaves like 1.
- R8: While `hop_en` is 0, the hop shift register holds its value and the dwell count restarts. The next hop therefore comes a full `dwell_len` cycles after `hop_en` returns to 1.
- R9: With `phase_inc` at 0 and the selected offset at 0, the sample stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_inc | input | 24 | Base phase step per clock |
| fsk_sym | input | 2 | Offset register index in keyed mode |
| hop_en | input | 1 | 1 selects hopping mode |
| dwell_len | input | 16 | Cycles between hops (0 behaves like 1) |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_sel | input | 2 | Offset register to write |
| ofs_data | input | 24 | Offset value to write |
| sample | output | 8 | Signed output sample |
| sample_valid | output | 1 | Pipeline filled since reset |

## Verification
The bench builds the block with its default parameters: a 24-bit phase, 1024 table entries, 8-bit samples and a 16-bit dwell count. These sizes are small enough that a step of 2^14 walks every table address in order, so the whole table is compared against an arithmetic sine. Odd step words then push the phase through many wraps. The bench keeps its own copy of the phase, the select and the shift-register state, so it can predict every sample under keyed switching, hopping with dwell lengths of 0, 1 and 5, pauses in hopping and a reset in the middle of a run.

// File: rtl/hop_nco.sv
module hop_nco #(
  parameter int ACC_W = 24,
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 8,
  parameter int DWELL_W = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ACC_W-1:0]         phase_inc,
  input  logic [1:0]               fsk_sym,
  input  logic                     hop_en,
  input  logic [DWELL_W-1:0]       dwell_len,
  input  logic                     ofs_we,
  input  logic [1:0]               ofs_sel,
  input  logic [ACC_W-1:0]         ofs_data,
  output logic signed [SAMP_W-1:0] sample,
  output logic                     sample_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP = (1 << (SAMP_W - 1)) - 1;
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic signed [SAMP_W-1:0] sine_at(int k);
    real x;
    x = real'(AMP) * $sin(TWO_PI * real'(k) / real'(DEPTH));
    if (x >= 0.0) return SAMP_W'($rtoi(x + 0.5));
    return SAMP_W'(-$rtoi(0.5 - x));
  endfunction

  logic signed [SAMP_W-1:0] rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    localparam logic signed [SAMP_W-1:0] V = sine_at(k);
    assign rom[k] = V;
  end

  logic [ACC_W-1:0]         acc_q;
  logic [ACC_W-1:0]         ofs_q [4];
  logic [1:0]               sel_q;
  logic [15:0]              lfsr_q;
  logic [DWELL_W-1:0]       dwell_q;
  logic signed [SAMP_W-1:0] rom_q, sample_q;
  logic [1:0]               vld_q;

  wire [ADDR_W-1:0] addr     = acc_q[ACC_W-1 -: ADDR_W];
  wire [ACC_W-1:0]  ofs_cur  = ofs_q[sel_q];
  wire              lfsr_fb  = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  wire              dwell_end = ({1'b0, dwell_q} + 1'b1) >= {1'b0, dwell_len};
  wire              hop_step = hop_en & dwell_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      for (int i = 0; i < 4; i++) ofs_q[i] <= '0;
      sel_q    <= '0;
      lfsr_q   <= LFSR_SEED;
      dwell_q  <= '0;
      rom_q    <= '0;
      sample_q <= '0;
      vld_q    <= '0;
    end else begin
      if (ofs_we) ofs_q[ofs_sel] <= ofs_data;
      acc_q    <= acc_q + phase_inc + ofs_cur;
      sel_q    <= hop_en ? lfsr_q[1:0] : fsk_sym;
      if (hop_step) lfsr_q <= {lfsr_q[14:0], lfsr_fb};
      dwell_q  <= (hop_en && !dwell_end) ? dwell_q + 1'b1 : '0;
      rom_q    <= rom[addr];
      sample_q <= rom_q;
      vld_q    <= {vld_q[0], 1'b1};
    end
  end

  assign sample       = sample_q;
  assign sample_valid = vld_q[1];
endmodule

module hop_nco_chk #(
  parameter int ACC_W = 24,
  parameter int SAMP_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ACC_W-1:0]         phase_inc,
  input logic [1:0]               fsk_sym,
  input logic                     hop_en,
  input logic [ACC_W-1:0]         acc_q,
  input logic [ACC_W-1:0]         ofs_cur,
  input logic [1:0]               sel_q,
  input logic [15:0]              lfsr_q,
  input logic signed [SAMP_W-1:0] sample,
  input logic                     sample_valid
);
  localparam logic signed [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

  assert_valid_after_two_R1: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (!$past(rst) && !$past(rst, 2)));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_q == ACC_W'($past(acc_q) + $past(phase_inc) + $past(ofs_cur)));

  assert_no_most_negative_R3: assert property (@(posedge clk) disable iff (rst)
    sample != MOST_NEG);

  assert_sym_select_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hop_en)) |-> sel_q == $past(fsk_sym));

  assert_hop_select_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hop_en)) |-> sel_q == $past(lfsr_q[1:0]));

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 16'h0);

  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hop_en)) |-> $stable(lfsr_q));
endmodule

bind hop_nco hop_nco_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst(rst), .phase_inc(phase_inc), .fsk_sym(fsk_sym), .hop_en(hop_en),
  .acc_q(acc_q), .ofs_cur(ofs_cur), .sel_q(sel_q), .lfsr_q(lfsr_q),
  .sample(sample), .sample_valid(sample_valid)
);

// File: tb/hop_nco_tb.sv
module hop_nco_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] phase_inc = '0;
  logic [1:0]  fsk_sym = '0;
  logic        hop_en = 1'b0;
  logic [15:0] dwell_len = '0;
  logic        ofs_we = 1'b0;
  logic [1:0]  ofs_sel = '0;
  logic [23:0] ofs_data = '0;
  logic signed [7:0] sample;
  logic        sample_valid;

  always #10 clk = ~clk;

  hop_nco u_dut (
    .clk(clk), .rst(rst), .phase_inc(phase_inc), .fsk_sym(fsk_sym), .hop_en(hop_en),
    .dwell_len(dwell_len), .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_data(ofs_data),
    .sample(sample), .sample_valid(sample_valid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  function automatic logic signed [7:0] ref_sine(logic [9:0] a);
    real x;
    x = 127.0 * $sin(6.283185307179586 * real'(a) / 1024.0);
    if (x >= 0.0) return 8'($rtoi(x + 0.5));
    return 8'(-$rtoi(0.5 - x));
  endfunction

  // Reference state built from the requirements
  logic [23:0] m_acc, m_ofs [4];
  logic [1:0]  m_sel;
  logic [15:0] m_lfsr, m_cnt;
  logic signed [7:0] m_p1, m_p2;
  logic [1:0]  m_v;

  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_sel <= '0; m_lfsr <= 16'hACE1; m_cnt <= '0;
      m_p1 <= '0; m_p2 <= '0; m_v <= '0;
      for (int i = 0; i < 4; i++) m_ofs[i] <= '0;
    end else begin
      automatic int period = (dwell_len == 0) ? 1 : int'(dwell_len);
      if (ofs_we) m_ofs[ofs_sel] <= ofs_data;
      m_acc <= m_acc + phase_inc + m_ofs[m_sel];
      m_sel <= hop_en ? m_lfsr[1:0] : fsk_sym;
      if (hop_en) begin
        if (int'(m_cnt) + 1 >= period) begin
          m_cnt  <= '0;
          m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end else m_cnt <= m_cnt + 1'b1;
      end else m_cnt <= '0;
      m_p1 <= ref_sine(m_acc[23:14]);
      m_p2 <= m_p1;
      m_v  <= {m_v[0], 1'b1};
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(rst ? "R1" : cur_req, 32'(sample), 32'(m_p2));
      check("R1", 32'(sample_valid), 32'(m_v[1]));
    end
  end

  task automatic wr_ofs(logic [1:0] s, logic [23:0] d);
    ofs_we = 1'b1; ofs_sel = s; ofs_data = d;
    @(negedge clk);
    ofs_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: every table address in order
    cur_req = "R3";
    phase_inc = 24'h004000;
    repeat (1030) @(negedge clk);
    // R2: odd step words, many wraps
    cur_req = "R2";
    phase_inc = 24'h5A5A5B;
    repeat (1500) @(negedge clk);
    phase_inc = 24'hFFF001;
    repeat (800) @(negedge clk);
    // R5 and R4: offsets and keyed switching
    cur_req = "R5";
    phase_inc = 24'h012345;
    wr_ofs(2'd0, 24'h000000);
    wr_ofs(2'd1, 24'h031000);
    wr_ofs(2'd2, 24'hF80123);
    wr_ofs(2'd3, 24'h100007);
    cur_req = "R4";
    for (int r = 0; r < 12; r++) begin
      fsk_sym = 2'(r * 3 + 1);
      repeat (37) @(negedge clk);
    end
    // R6 and R7: hopping with varying dwell, symbol toggled
    cur_req = "R6";
    hop_en = 1'b1; dwell_len = 16'd5;
    for (int r = 0; r < 400; r++) begin
      fsk_sym = 2'(r);
      @(negedge clk);
    end
    cur_req = "R7";
    dwell_len = 16'd0;
    repeat (600) @(negedge clk);
    dwell_len = 16'd1;
    repeat (300) @(negedge clk);
    dwell_len = 16'd23;
    repeat (900) @(negedge clk);
    // R8: pause hopping then resume
    cur_req = "R8";
    hop_en = 1'b0;
    repeat (50) @(negedge clk);
    hop_en = 1'b1; dwell_len = 16'd7;
    repeat (3) @(negedge clk);
    hop_en = 1'b0;
    repeat (10) @(negedge clk);
    hop_en = 1'b1;
    repeat (200) @(negedge clk);
    // R9: zero step, zero offset
    cur_req = "R9";
    hop_en = 1'b0; fsk_sym = 2'd0; phase_inc = '0;
    wr_ofs(2'd0, 24'h000000);
    repeat (100) @(negedge clk);
    // R1: reset during a run
    cur_req = "R1";
    rst = 1'b1; phase_inc = 24'h0ABCDE;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cur_req = "R2";
    repeat (300) @(negedge clk);
    finish_run();
  end
endmodule